// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block sits beside the decode stage of a five-stage in-order pipeline and decides, in the same cycle, where each source operand of the decoding instruction should come from. Three later stages can hold an instruction that writes a register: execute, memory access and write-back. Each of them may still own the newest value of a register that decode wants to read. For each of the two source operands, the block compares the source register number with the destination of every in-flight writer. It then picks the youngest matching writer and delivers that stage's result in place of the register-file read.

Some values cannot be bypassed yet. A load still in execute has no data. A load in the memory stage has data only once the memory has answered. In these cases the block raises a stall. The stall holds the decoding instruction by pulling decode's upstream ready and downstream valid low until the producer moves far enough along. The block holds no state. All outputs are pure functions of the present inputs, so a stall clears in the same cycle that its cause goes away.

Top module: `hz_raw_unit`

## Requirements
- R1: A stage matches a source operand only when that stage's valid flag is 1, its write-enable is 1, its destination equals the source register number, the source is marked as read, and the source number is not 0. Any other stage contents leave the select at 00.
- R2: A source whose used flag is 0 never forwards and never stalls. Its select is 00 and its data is the register-file value, whatever the stages hold.
- R3: Source register 0 never forwards and never stalls, even when a valid writing stage names destination 0 (including a load).
- R4: Each select is 2 bits: 00 = register file, 01 = execute result, 10 = memory-stage result, 11 = write-back result. The operand data output equals the value of the selected source.
- R5: When several stages match one operand, the youngest wins. Execute (01) has priority over memory (10), and memory has priority over write-back (11).
- R6: If the youngest match of either operand is a load in execute, stall is 1. The select still names execute (01).
- R7: If the youngest match is a load in the memory stage, stall is 1 while the load-data-valid flag is 0. When that flag is 1, the operand forwards from the memory stage (10) with no stall.
- R8: Only the youngest match decides a stall. A matching load in write-back forwards without a stall. An unfinished older load hidden behind a younger non-load match causes no stall.
- R9: While stall is 1, decode's input-ready and output-valid are both 0. Otherwise input-ready equals the execute stage's input-ready and output-valid equals decode's valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs1_idx | input | AW | First source register number of the decoding instruction |
| rs2_idx | input | AW | Second source register number |
| rs1_used | input | 1 | Instruction reads the first source |
| rs2_used | input | 1 | Instruction reads the second source |
| rf_rs1_data | input | XLEN | Register-file read value for the first source |
| rf_rs2_data | input | XLEN | Register-file read value for the second source |
| ex_rd | input | AW | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_valid | input | 1 | Execute stage holds an instruction |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_result | input | XLEN | Execute-stage result |
| ls_rd | input | AW | Destination register of the memory-stage instruction |
| ls_wen | input | 1 | Memory-stage instruction writes a register |
| ls_valid | input | 1 | Memory stage holds an instruction |
| ls_is_load | input | 1 | Memory-stage instruction is a load |
| ls_load_done | input | 1 | Load data for the memory stage has returned |
| ls_result | input | XLEN | Memory-stage result (load data when the stage holds a load) |
| wb_rd | input | AW | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_result | input | XLEN | Write-back result |
| id_valid | input | 1 | Decode stage holds an instruction |
| ex_in_ready | input | 1 | Execute stage can accept an instruction |
| fwd1_sel | output | 2 | Source select for the first operand |
| fwd2_sel | output | 2 | Source select for the second operand |
| fwd1_data | output | XLEN | Resolved first operand |
| fwd2_data | output | XLEN | Resolved second operand |
| stall | output | 1 | Decode must hold its instruction |
| id_in_ready | output | 1 | Decode stage input-ready after the interlock |
| id_out_valid | output | 1 | Decode stage output-valid after the interlock |

## Verification
The bench targets the following corner cases:

- **Three stages matching at once.** A design that picked the oldest writer would feed decode a stale value from write-back.
- **Register 0 and unused second sources.** These are the places where a careless compare invents a dependency. It would also stall for nothing on a load that targets x0.
- **Load timing.** Loads in execute, in the memory stage with and without returned data, and in write-back are each tried. A design that stalled too little would bypass garbage from a load still in flight. One that stalled too much would block decode behind a load whose value has already arrived.
- **Random coverage.** Thousands of random mixes over a narrow range of register numbers produce frequent collisions, so disagreements in priority or gating show up quickly.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int NUM_STG = 3;
  localparam int NUM_SRC = 2;
  localparam int STG_EX  = 0;
  localparam int STG_LS  = 1;
  localparam int STG_WB  = 2;

  typedef enum logic [1:0] {
    SEL_RF = 2'b00,
    SEL_EX = 2'b01,
    SEL_LS = 2'b10,
    SEL_WB = 2'b11
  } fwd_sel_e;

  // youngest matching stage wins: execute, then memory, then write-back
  function automatic fwd_sel_e pick_youngest(input logic [NUM_STG-1:0] hit);
    if (hit[STG_EX])      return SEL_EX;
    else if (hit[STG_LS]) return SEL_LS;
    else if (hit[STG_WB]) return SEL_WB;
    else                  return SEL_RF;
  endfunction

endpackage

// File: rtl/hz_src_match.sv
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] rs_idx,
  input  logic          rs_used,
  input  logic [AW-1:0] st_rd,
  input  logic          st_valid,
  input  logic          st_wen,
  output logic          hit
);
  logic rs_live;
  logic st_writes;

  assign rs_live   = rs_used && (rs_idx != '0);
  assign st_writes = st_valid && st_wen;
  assign hit       = rs_live && st_writes && (st_rd == rs_idx);
endmodule

// File: rtl/hz_operand_path.sv
module hz_operand_path
  import hz_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [NUM_STG-1:0] hit,
  input  logic               ex_is_load,
  input  logic               ls_is_load,
  input  logic               ls_load_done,
  input  logic [XLEN-1:0]    rf_data,
  input  logic [XLEN-1:0]    ex_data,
  input  logic [XLEN-1:0]    ls_data,
  input  logic [XLEN-1:0]    wb_data,
  output fwd_sel_e           sel,
  output logic [XLEN-1:0]    value,
  output logic               stall_req
);
  logic ex_load_block;
  logic ls_load_block;

  assign sel           = pick_youngest(hit);
  assign ex_load_block = (sel == SEL_EX) && ex_is_load;
  assign ls_load_block = (sel == SEL_LS) && ls_is_load && !ls_load_done;
  assign stall_req     = ex_load_block || ls_load_block;

  always_comb begin
    unique case (sel)
      SEL_EX:  value = ex_data;
      SEL_LS:  value = ls_data;
      SEL_WB:  value = wb_data;
      default: value = rf_data;
    endcase
  end
endmodule

// File: rtl/hz_raw_unit.sv
module hz_raw_unit
  import hz_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input  logic [AW-1:0]   rs1_idx,
  input  logic [AW-1:0]   rs2_idx,
  input  logic            rs1_used,
  input  logic            rs2_used,
  input  logic [XLEN-1:0] rf_rs1_data,
  input  logic [XLEN-1:0] rf_rs2_data,
  input  logic [AW-1:0]   ex_rd,
  input  logic            ex_wen,
  input  logic            ex_valid,
  input  logic            ex_is_load,
  input  logic [XLEN-1:0] ex_result,
  input  logic [AW-1:0]   ls_rd,
  input  logic            ls_wen,
  input  logic            ls_valid,
  input  logic            ls_is_load,
  input  logic            ls_load_done,
  input  logic [XLEN-1:0] ls_result,
  input  logic [AW-1:0]   wb_rd,
  input  logic            wb_wen,
  input  logic            wb_valid,
  input  logic [XLEN-1:0] wb_result,
  input  logic            id_valid,
  input  logic            ex_in_ready,
  output logic [1:0]      fwd1_sel,
  output logic [1:0]      fwd2_sel,
  output logic [XLEN-1:0] fwd1_data,
  output logic [XLEN-1:0] fwd2_data,
  output logic            stall,
  output logic            id_in_ready,
  output logic            id_out_valid
);
  logic [AW-1:0]      st_rd    [NUM_STG];
  logic [NUM_STG-1:0] st_valid;
  logic [NUM_STG-1:0] st_wen;
  logic [AW-1:0]      src_idx  [NUM_SRC];
  logic [NUM_SRC-1:0] src_used;
  logic [XLEN-1:0]    src_rf   [NUM_SRC];
  logic [NUM_STG-1:0] op_hit   [NUM_SRC];
  fwd_sel_e           op_sel   [NUM_SRC];
  logic [XLEN-1:0]    op_val   [NUM_SRC];
  logic [NUM_SRC-1:0] op_stall;

  always_comb begin
    st_rd[STG_EX] = ex_rd;
    st_rd[STG_LS] = ls_rd;
    st_rd[STG_WB] = wb_rd;
    st_valid      = {wb_valid, ls_valid, ex_valid};
    st_wen        = {wb_wen, ls_wen, ex_wen};
    src_idx[0]    = rs1_idx;
    src_idx[1]    = rs2_idx;
    src_used      = {rs2_used, rs1_used};
    src_rf[0]     = rf_rs1_data;
    src_rf[1]     = rf_rs2_data;
  end

  for (genvar o = 0; o < NUM_SRC; o++) begin : g_src
    for (genvar s = 0; s < NUM_STG; s++) begin : g_stg
      hz_src_match #(.AW(AW)) match_i (
        .rs_idx  (src_idx[o]),
        .rs_used (src_used[o]),
        .st_rd   (st_rd[s]),
        .st_valid(st_valid[s]),
        .st_wen  (st_wen[s]),
        .hit     (op_hit[o][s])
      );
    end

    hz_operand_path #(.XLEN(XLEN)) path_i (
      .hit         (op_hit[o]),
      .ex_is_load  (ex_is_load),
      .ls_is_load  (ls_is_load),
      .ls_load_done(ls_load_done),
      .rf_data     (src_rf[o]),
      .ex_data     (ex_result),
      .ls_data     (ls_result),
      .wb_data     (wb_result),
      .sel         (op_sel[o]),
      .value       (op_val[o]),
      .stall_req   (op_stall[o])
    );
  end

  assign fwd1_sel     = op_sel[0];
  assign fwd2_sel     = op_sel[1];
  assign fwd1_data    = op_val[0];
  assign fwd2_data    = op_val[1];
  assign stall        = |op_stall;
  assign id_in_ready  = ex_in_ready && !stall;
  assign id_out_valid = id_valid && !stall;
endmodule

// File: rtl/hz_raw_unit_chk.sv
module hz_raw_unit_chk #(
  parameter int XLEN = 32,
  parameter int AW   = 5
) (
  input logic [AW-1:0]   rs1_idx,
  input logic [AW-1:0]   rs2_idx,
  input logic            rs1_used,
  input logic            rs2_used,
  input logic [AW-1:0]   ex_rd,
  input logic            ex_wen,
  input logic            ex_valid,
  input logic            ex_is_load,
  input logic            ls_is_load,
  input logic [XLEN-1:0] ex_result,
  input logic [1:0]      fwd1_sel,
  input logic [1:0]      fwd2_sel,
  input logic [XLEN-1:0] fwd1_data,
  input logic            stall,
  input logic            id_in_ready,
  input logic            id_out_valid
);
  always_comb begin
    p_x0_src1_r3: assert (rs1_idx != '0 || fwd1_sel == 2'b00)
      else $error("x0 source 1 forwarded");
    p_x0_src2_r3: assert (rs2_idx != '0 || fwd2_sel == 2'b00)
      else $error("x0 source 2 forwarded");
    p_unused_src2_r2: assert (rs2_used || fwd2_sel == 2'b00)
      else $error("unused source 2 forwarded");
    p_stall_gate_r9: assert (!stall || (!id_in_ready && !id_out_valid))
      else $error("stall did not gate decode handshake");
    p_ex_data_r4: assert (fwd1_sel != 2'b01 || fwd1_data == ex_result)
      else $error("execute select without execute data");
    p_ex_prio_r5: assert (!(rs1_used && rs1_idx != '0 && ex_valid && ex_wen && ex_rd == rs1_idx)
                          || fwd1_sel == 2'b01)
      else $error("execute match lost priority");
    p_ex_load_stall_r6: assert (!(fwd1_sel == 2'b01 && ex_is_load) || stall)
      else $error("load in execute bypassed");
    p_stall_cause_r8: assert (!stall || ex_is_load || ls_is_load)
      else $error("stall without any load");
  end
endmodule

bind hz_raw_unit hz_raw_unit_chk #(.XLEN(XLEN), .AW(AW)) chk_i (
  .rs1_idx     (rs1_idx),
  .rs2_idx     (rs2_idx),
  .rs1_used    (rs1_used),
  .rs2_used    (rs2_used),
  .ex_rd       (ex_rd),
  .ex_wen      (ex_wen),
  .ex_valid    (ex_valid),
  .ex_is_load  (ex_is_load),
  .ls_is_load  (ls_is_load),
  .ex_result   (ex_result),
  .fwd1_sel    (fwd1_sel),
  .fwd2_sel    (fwd2_sel),
  .fwd1_data   (fwd1_data),
  .stall       (stall),
  .id_in_ready (id_in_ready),
  .id_out_valid(id_out_valid)
);

// File: tb/hz_raw_unit_tb_top.sv
`timescale 1ns/1ps
module hz_raw_unit_tb_top;
  localparam int XLEN = 32;
  localparam int AW   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [AW-1:0]   rs1_idx, rs2_idx, ex_rd, ls_rd, wb_rd;
  logic            rs1_used, rs2_used;
  logic [XLEN-1:0] rf_rs1_data, rf_rs2_data, ex_result, ls_result, wb_result;
  logic            ex_wen, ex_valid, ex_is_load;
  logic            ls_wen, ls_valid, ls_is_load, ls_load_done;
  logic            wb_wen, wb_valid, id_valid, ex_in_ready;
  logic [1:0]      fwd1_sel, fwd2_sel;
  logic [XLEN-1:0] fwd1_data, fwd2_data;
  logic            stall, id_in_ready, id_out_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  hz_raw_unit #(.XLEN(XLEN), .AW(AW)) dut_i (.*);

  task automatic check(string req, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_all();
    rs1_idx = 0; rs2_idx = 0; rs1_used = 1; rs2_used = 1;
    rf_rs1_data = 32'h1111_0001; rf_rs2_data = 32'h2222_0002;
    ex_rd = 0; ex_wen = 0; ex_valid = 0; ex_is_load = 0; ex_result = 32'hE0E0_E0E0;
    ls_rd = 0; ls_wen = 0; ls_valid = 0; ls_is_load = 0; ls_load_done = 0;
    ls_result = 32'h1515_1515;
    wb_rd = 0; wb_wen = 0; wb_valid = 0; wb_result = 32'hB0B0_B0B0;
    id_valid = 1; ex_in_ready = 1;
  endtask

  // behavioural reference: walk stages youngest first
  function automatic int ref_sel(int rs, bit used);
    int rd[3]; bit v[3]; bit w[3];
    rd = '{int'(ex_rd), int'(ls_rd), int'(wb_rd)};
    v  = '{ex_valid, ls_valid, wb_valid};
    w  = '{ex_wen, ls_wen, wb_wen};
    if (!used || rs == 0) return 0;
    for (int s = 0; s < 3; s++)
      if (v[s] && w[s] && rd[s] == rs) return s + 1;
    return 0;
  endfunction

  function automatic bit ref_blocks(int sel);
    return (sel == 1 && ex_is_load) || (sel == 2 && ls_is_load && !ls_load_done);
  endfunction

  function automatic logic [XLEN-1:0] ref_data(int sel, logic [XLEN-1:0] rf);
    case (sel)
      1: return ex_result;
      2: return ls_result;
      3: return wb_result;
      default: return rf;
    endcase
  endfunction

  task automatic compare_all(string req);
    int s1, s2; bit st;
    s1 = ref_sel(int'(rs1_idx), rs1_used);
    s2 = ref_sel(int'(rs2_idx), rs2_used);
    st = ref_blocks(s1) || ref_blocks(s2);
    check(req, "sel1", 32'(fwd1_sel), 32'(s1));
    check(req, "sel2", 32'(fwd2_sel), 32'(s2));
    check(req, "data1", fwd1_data, ref_data(s1, rf_rs1_data));
    check(req, "data2", fwd2_data, ref_data(s2, rf_rs2_data));
    check(req, "stall", 32'(stall), 32'(st));
    check(req, "in_ready", 32'(id_in_ready), 32'(ex_in_ready && !st));
    check(req, "out_valid", 32'(id_out_valid), 32'(id_valid && !st));
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    clear_all();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    settle();
    // reset/idle state
    check("R9", "idle sel1", 32'(fwd1_sel), 0);
    check("R9", "idle stall", 32'(stall), 0);
    check("R9", "idle ready", 32'(id_in_ready), 1);
    check("R4", "idle rf data", fwd1_data, 32'h1111_0001);

    // R1: valid or write-enable missing blocks the match
    @(posedge clk); #1 rs1_idx = 5; ex_rd = 5; ex_wen = 1; ex_valid = 0;
    settle(); check("R1", "invalid ex", 32'(fwd1_sel), 0);
    @(posedge clk); #1 ex_valid = 1; ex_wen = 0;
    settle(); check("R1", "no-write ex", 32'(fwd1_sel), 0);
    @(posedge clk); #1 ex_wen = 1;
    settle(); check("R1", "ex match", 32'(fwd1_sel), 1);
    check("R4", "ex data", fwd1_data, 32'hE0E0_E0E0);

    // R2: unused sources
    @(posedge clk); #1 rs2_idx = 5; rs2_used = 0; rs1_used = 0;
    settle(); check("R2", "unused src2", 32'(fwd2_sel), 0);
    check("R2", "unused src1", 32'(fwd1_sel), 0);
    check("R2", "unused data2", fwd2_data, 32'h2222_0002);

    // R3: register 0, even against a load
    @(posedge clk); #1 clear_all(); ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_rd = 0;
    settle(); check("R3", "x0 sel", 32'(fwd1_sel), 0);
    check("R3", "x0 no stall", 32'(stall), 0);

    // R5: priority
    @(posedge clk); #1 clear_all(); rs2_idx = 7;
    ex_rd = 7; ex_wen = 1; ex_valid = 1;
    ls_rd = 7; ls_wen = 1; ls_valid = 1;
    wb_rd = 7; wb_wen = 1; wb_valid = 1;
    settle(); check("R5", "all match", 32'(fwd2_sel), 1);
    @(posedge clk); #1 ex_valid = 0;
    settle(); check("R5", "ls over wb", 32'(fwd2_sel), 2);
    check("R4", "ls data", fwd2_data, 32'h1515_1515);
    @(posedge clk); #1 ls_valid = 0;
    settle(); check("R5", "wb only", 32'(fwd2_sel), 3);
    check("R4", "wb data", fwd2_data, 32'hB0B0_B0B0);

    // R6: load in execute
    @(posedge clk); #1 clear_all(); rs1_idx = 9; ex_rd = 9; ex_wen = 1; ex_valid = 1; ex_is_load = 1;
    settle(); check("R6", "ex load stall", 32'(stall), 1);
    check("R6", "ex load sel", 32'(fwd1_sel), 1);
    check("R9", "stall ready", 32'(id_in_ready), 0);
    check("R9", "stall valid", 32'(id_out_valid), 0);

    // R7: load in memory stage
    @(posedge clk); #1 clear_all(); rs2_idx = 4; ls_rd = 4; ls_wen = 1; ls_valid = 1; ls_is_load = 1;
    settle(); check("R7", "ls load pending", 32'(stall), 1);
    @(posedge clk); #1 ls_load_done = 1;
    settle(); check("R7", "ls load done stall", 32'(stall), 0);
    check("R7", "ls load done sel", 32'(fwd2_sel), 2);

    // R8: wb load and hidden older load
    @(posedge clk); #1 clear_all(); rs1_idx = 6; wb_rd = 6; wb_wen = 1; wb_valid = 1;
    settle(); check("R8", "wb load stall", 32'(stall), 0);
    check("R8", "wb load sel", 32'(fwd1_sel), 3);
    @(posedge clk); #1 clear_all(); rs1_idx = 6;
    ex_rd = 6; ex_wen = 1; ex_valid = 1;
    ls_rd = 6; ls_wen = 1; ls_valid = 1; ls_is_load = 1; ls_load_done = 0;
    settle(); check("R8", "hidden load stall", 32'(stall), 0);
    check("R8", "hidden load sel", 32'(fwd1_sel), 1);

    // R9: handshake pass-through without stall
    @(posedge clk); #1 clear_all(); ex_in_ready = 0; id_valid = 1;
    settle(); check("R9", "ready follows ex", 32'(id_in_ready), 0);
    check("R9", "valid follows id", 32'(id_out_valid), 1);

    // random compare every clock: R1 R4 R5 R6 R7 R8 R9
    for (int n = 0; n < 3000; n++) begin
      @(posedge clk); #1
      rs1_idx = AW'($urandom_range(0, 3)); rs2_idx = AW'($urandom_range(0, 3));
      rs1_used = 1'($urandom); rs2_used = 1'($urandom);
      rf_rs1_data = $urandom; rf_rs2_data = $urandom;
      ex_rd = AW'($urandom_range(0, 3)); ex_wen = 1'($urandom); ex_valid = 1'($urandom);
      ex_is_load = 1'($urandom); ex_result = $urandom;
      ls_rd = AW'($urandom_range(0, 3)); ls_wen = 1'($urandom); ls_valid = 1'($urandom);
      ls_is_load = 1'($urandom); ls_load_done = 1'($urandom); ls_result = $urandom;
      wb_rd = AW'($urandom_range(0, 3)); wb_wen = 1'($urandom); wb_valid = 1'($urandom);
      wb_result = $urandom;
      id_valid = 1'($urandom); ex_in_ready = 1'($urandom);
      settle();
      compare_all("R1 R5 R6 R7 R9");
    end

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule